// File: doc/BRIEF.md
# Channelised Link Time-Slot Mapper

This block sits between a framed T1/J1 or E1 serial line and a bank of per-channel HDLC engines. On receive, the line framer presents one bit per enabled cycle and marks the first bit of each frame. The block keeps track of the bit position inside the frame and looks up the time-slot that owns the bit in a programmable assignment table. It then hands the bit to the logical channel named there, together with a valid strobe and the channel index. On transmit it runs the same position tracking. It asks the owning channel for a bit with a request strobe and channel index, and drives the serial line one cycle later.

Each of the 32 table entries holds an enable bit, a 56 kbit/s format bit and a channel number. The table is loaded through a simple write port. Any number of slots may share one channel, up to all 24 payload slots of a T1 frame or all 31 payload slots of an E1 frame. A per-link clear-channel mode ignores the table and carries every bit position, framing positions included, for one configured channel. A first-bit marker on both sides lets transparent-mode channels keep their octets aligned to slot boundaries.

The position tracker is a three-state machine. HUNT waits for the first frame marker. FBIT is the T1 framing bit. SLOT walks slot and bit counters. The transitions are: HUNT to FBIT or SLOT on a frame marker; FBIT to SLOT after one bit; SLOT to SLOT within and across slots; SLOT to FBIT at the end of a T1 frame; SLOT to SLOT (slot 0) at the end of an E1 frame. A frame marker moves the machine to frame position 0 from any state.

Top module: `tslot_mapper`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rx_valid` and `tx_req` are 0 and `tx_line` is 1. Reset also disables all 32 table entries.
- R2: A T1 frame is 193 bits: one framing bit, then slots 0..23 of 8 bits each. An E1 frame is 256 bits: slots 0..31 of 8 bits each. Bit 0 of each slot is its MSB and is sent first. The bit seen with `rx_sync`/`tx_sync` high is frame position 0, and the marker realigns the position at any time. Before the first marker no bit is carried and `tx_line` is driven to 1.
- R3: A received payload bit of an enabled slot gives `rx_valid`=1 one cycle later. In that cycle `rx_data` is the received bit and `rx_chan` is the slot's channel number.
- R4: A slot whose entry is disabled gives no receive strobe and no transmit request, and its bits are sent as 1.
- R5: In a slot set to 56 kbit/s format, bit 7 (the LSB) gives no receive strobe and no transmit request, and is sent as 1. Bits 0..6 are carried as usual.
- R6: Without clear-channel mode, the T1 framing bit and all bits of E1 slot 0 are never carried. On transmit, `tx_line` at these positions copies `tx_ovh`.
- R7: In clear-channel mode, every frame position is carried for channel `clear_chan` in both directions, whatever the table holds.
- R8: `rx_first` and `tx_req_first` are 1 only with a carried bit that is bit 0 of a slot.
- R9: `tx_req` and `tx_req_chan` follow the current transmit bit in the same cycle. `tx_line` takes the value of `tx_chan_bit` at the next clock edge.
- R10: A cycle with the enable low advances no position. With `rx_en` low there is no receive strobe in the next cycle. With `tx_en` low there is no request and `tx_line` holds its value.
- R11: A table write takes effect for the first bit that follows the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_e1 | input | 1 | 1 = E1 frame, 0 = T1/J1 frame |
| clear_mode | input | 1 | Clear-channel mode |
| clear_chan | input | CHW | Channel used in clear-channel mode |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Slot number to write |
| tbl_en | input | 1 | Entry enable |
| tbl_f56 | input | 1 | Entry 56 kbit/s format |
| tbl_chan | input | CHW | Entry channel number |
| rx_en | input | 1 | Receive bit present |
| rx_sync | input | 1 | Receive bit is frame position 0 |
| rx_bit | input | 1 | Receive line bit |
| rx_valid | output | 1 | Bit strobe to a channel |
| rx_data | output | 1 | Bit to the channel |
| rx_chan | output | CHW | Receiving channel index |
| rx_first | output | 1 | Bit is the first bit of a slot |
| tx_en | input | 1 | Transmit bit slot present |
| tx_sync | input | 1 | Transmit bit is frame position 0 |
| tx_ovh | input | 1 | Overhead bit for framing positions |
| tx_req | output | 1 | Bit request to a channel |
| tx_req_chan | output | CHW | Requested channel index |
| tx_req_first | output | 1 | Request is for the first bit of a slot |
| tx_chan_bit | input | 1 | Bit returned by the requested channel |
| tx_line | output | 1 | Transmit line bit |

## Verification
The bench runs T1 and E1 framing, each in channelised and clear-channel mode, with three arithmetic table patterns. The first mixes disabled, 56 kbit/s and 64 kbit/s slots spread across channels. The second gives every slot to one channel, which covers the 24 and 31 slot maxima. The third is a clear-channel run that must ignore the table. Random gaps in the enables separate position advance from clock advance. A stretch before the first frame marker and a marker at an odd offset test hunting and realignment. A table rewrite in the middle of a frame tells a live lookup apart from a cached one. Because the transmit data depends on the requested index, a wrong channel shows up on the line as well as on the request.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
    localparam int T1_SLOTS = 24;
    localparam int E1_SLOTS = 32;
    localparam int NSLOT    = 32;
    localparam int SLOTW    = $clog2(NSLOT);
    localparam int OCT      = 8;
    localparam int BITW     = $clog2(OCT);

    typedef enum logic [1:0] {
        PT_HUNT,
        PT_FBIT,
        PT_SLOT
    } pos_state_e;

    typedef enum logic [1:0] {
        BC_NONE,
        BC_OVH,
        BC_FILL,
        BC_DATA
    } bit_class_e;
endpackage

// File: rtl/tsm_pos_tracker.sv
module tsm_pos_tracker
    import tsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fsync,
    input  logic             e1,
    output logic             cur_valid,
    output logic             cur_fbit,
    output logic [SLOTW-1:0] cur_slot,
    output logic [BITW-1:0]  cur_bit
);
    pos_state_e       state_q, state_d;
    logic [SLOTW-1:0] slot_q, slot_d;
    logic [BITW-1:0]  bit_q, bit_d;
    logic [SLOTW-1:0] last_slot;

    assign last_slot = e1 ? SLOTW'(E1_SLOTS - 1) : SLOTW'(T1_SLOTS - 1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PT_HUNT;
            slot_q  <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            bit_q   <= bit_d;
        end
    end

    // position of the bit presented in this cycle
    always_comb begin
        cur_valid = 1'b0;
        cur_fbit  = 1'b0;
        cur_slot  = '0;
        cur_bit   = '0;
        if (en) begin
            if (fsync) begin
                cur_valid = 1'b1;
                cur_fbit  = !e1;
            end else begin
                unique case (state_q)
                    PT_HUNT: cur_valid = 1'b0;
                    PT_FBIT: begin
                        cur_valid = 1'b1;
                        cur_fbit  = 1'b1;
                    end
                    PT_SLOT: begin
                        cur_valid = 1'b1;
                        cur_slot  = slot_q;
                        cur_bit   = bit_q;
                    end
                    default: cur_valid = 1'b0;
                endcase
            end
        end
    end

    // next position
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        bit_d   = bit_q;
        if (cur_valid) begin
            if (cur_fbit) begin
                state_d = PT_SLOT;
                slot_d  = '0;
                bit_d   = '0;
            end else if (cur_bit != BITW'(OCT - 1)) begin
                state_d = PT_SLOT;
                slot_d  = cur_slot;
                bit_d   = cur_bit + 1'b1;
            end else if (cur_slot >= last_slot) begin
                state_d = e1 ? PT_SLOT : PT_FBIT;
                slot_d  = '0;
                bit_d   = '0;
            end else begin
                state_d = PT_SLOT;
                slot_d  = cur_slot + 1'b1;
                bit_d   = '0;
            end
        end
    end
endmodule

// File: rtl/tsm_slot_table.sv
module tsm_slot_table
    import tsm_pkg::*;
#(
    parameter int CHW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SLOTW-1:0] waddr,
    input  logic             wen,
    input  logic             wf56,
    input  logic [CHW-1:0]   wch,
    input  logic [SLOTW-1:0] a_slot,
    output logic             a_en,
    output logic             a_f56,
    output logic [CHW-1:0]   a_ch,
    input  logic [SLOTW-1:0] b_slot,
    output logic             b_en,
    output logic             b_f56,
    output logic [CHW-1:0]   b_ch
);
    logic [NSLOT-1:0]          en_q;
    logic [NSLOT-1:0]          f56_q;
    logic [NSLOT-1:0][CHW-1:0] ch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            f56_q <= '0;
            ch_q  <= '0;
        end else begin
            for (int s = 0; s < NSLOT; s++) begin
                if (we && waddr == SLOTW'(s)) begin
                    en_q[s]  <= wen;
                    f56_q[s] <= wf56;
                    ch_q[s]  <= wch;
                end
            end
        end
    end

    assign a_en  = en_q[a_slot];
    assign a_f56 = f56_q[a_slot];
    assign a_ch  = ch_q[a_slot];
    assign b_en  = en_q[b_slot];
    assign b_f56 = f56_q[b_slot];
    assign b_ch  = ch_q[b_slot];
endmodule

// File: rtl/tsm_classify.sv
module tsm_classify
    import tsm_pkg::*;
#(
    parameter int CHW = 3
) (
    input  logic             cur_valid,
    input  logic             cur_fbit,
    input  logic [SLOTW-1:0] cur_slot,
    input  logic [BITW-1:0]  cur_bit,
    input  logic             e1,
    input  logic             clear,
    input  logic [CHW-1:0]   clear_ch,
    input  logic             ent_en,
    input  logic             ent_f56,
    input  logic [CHW-1:0]   ent_ch,
    output bit_class_e       cls,
    output logic [CHW-1:0]   chan,
    output logic             first
);
    logic ovh_pos;
    logic lsb_drop;

    assign ovh_pos  = cur_fbit || (e1 && cur_slot == '0);
    assign lsb_drop = ent_f56 && (cur_bit == BITW'(OCT - 1));

    always_comb begin
        cls  = BC_NONE;
        chan = '0;
        if (!cur_valid) begin
            cls = BC_NONE;
        end else if (clear) begin
            cls  = BC_DATA;
            chan = clear_ch;
        end else if (ovh_pos) begin
            cls = BC_OVH;
        end else if (!ent_en || lsb_drop) begin
            cls = BC_FILL;
        end else begin
            cls  = BC_DATA;
            chan = ent_ch;
        end
    end

    assign first = (cls == BC_DATA) && !cur_fbit && (cur_bit == '0);
endmodule

// File: rtl/tslot_mapper.sv
module tslot_mapper
    import tsm_pkg::*;
#(
    parameter  int NCHAN = 8,
    localparam int CHW   = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_e1,
    input  logic             clear_mode,
    input  logic [CHW-1:0]   clear_chan,
    input  logic             tbl_we,
    input  logic [SLOTW-1:0] tbl_addr,
    input  logic             tbl_en,
    input  logic             tbl_f56,
    input  logic [CHW-1:0]   tbl_chan,
    input  logic             rx_en,
    input  logic             rx_sync,
    input  logic             rx_bit,
    output logic             rx_valid,
    output logic             rx_data,
    output logic [CHW-1:0]   rx_chan,
    output logic             rx_first,
    input  logic             tx_en,
    input  logic             tx_sync,
    input  logic             tx_ovh,
    output logic             tx_req,
    output logic [CHW-1:0]   tx_req_chan,
    output logic             tx_req_first,
    input  logic             tx_chan_bit,
    output logic             tx_line
);
    logic             rp_valid, rp_fbit, tp_valid, tp_fbit;
    logic [SLOTW-1:0] rp_slot, tp_slot;
    logic [BITW-1:0]  rp_bit, tp_bit;
    logic             re_en, re_f56, te_en, te_f56;
    logic [CHW-1:0]   re_ch, te_ch, rx_ch_d;
    bit_class_e       rx_cls, tx_cls;
    logic             rx_first_d;

    tsm_pos_tracker u_rx_pos (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .fsync(rx_sync), .e1(link_e1),
        .cur_valid(rp_valid), .cur_fbit(rp_fbit), .cur_slot(rp_slot), .cur_bit(rp_bit)
    );

    tsm_pos_tracker u_tx_pos (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .fsync(tx_sync), .e1(link_e1),
        .cur_valid(tp_valid), .cur_fbit(tp_fbit), .cur_slot(tp_slot), .cur_bit(tp_bit)
    );

    tsm_slot_table #(.CHW(CHW)) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr),
        .wen(tbl_en), .wf56(tbl_f56), .wch(tbl_chan),
        .a_slot(rp_slot), .a_en(re_en), .a_f56(re_f56), .a_ch(re_ch),
        .b_slot(tp_slot), .b_en(te_en), .b_f56(te_f56), .b_ch(te_ch)
    );

    tsm_classify #(.CHW(CHW)) u_rx_cls (
        .cur_valid(rp_valid), .cur_fbit(rp_fbit), .cur_slot(rp_slot), .cur_bit(rp_bit),
        .e1(link_e1), .clear(clear_mode), .clear_ch(clear_chan),
        .ent_en(re_en), .ent_f56(re_f56), .ent_ch(re_ch),
        .cls(rx_cls), .chan(rx_ch_d), .first(rx_first_d)
    );

    tsm_classify #(.CHW(CHW)) u_tx_cls (
        .cur_valid(tp_valid), .cur_fbit(tp_fbit), .cur_slot(tp_slot), .cur_bit(tp_bit),
        .e1(link_e1), .clear(clear_mode), .clear_ch(clear_chan),
        .ent_en(te_en), .ent_f56(te_f56), .ent_ch(te_ch),
        .cls(tx_cls), .chan(tx_req_chan), .first(tx_req_first)
    );

    assign tx_req = (tx_cls == BC_DATA);

    // receive hand-off register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= 1'b0;
            rx_chan  <= '0;
            rx_first <= 1'b0;
        end else begin
            rx_valid <= (rx_cls == BC_DATA);
            rx_first <= rx_first_d;
            if (rx_cls == BC_DATA) begin
                rx_data <= rx_bit;
                rx_chan <= rx_ch_d;
            end
        end
    end

    // transmit line register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_line <= 1'b1;
        end else if (tx_en) begin
            unique case (tx_cls)
                BC_NONE: tx_line <= 1'b1;
                BC_OVH:  tx_line <= tx_ovh;
                BC_FILL: tx_line <= 1'b1;
                BC_DATA: tx_line <= tx_chan_bit;
                default: tx_line <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
    parameter int CHW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           link_e1,
    input logic           clear_mode,
    input logic [CHW-1:0] clear_chan,
    input logic           rx_en,
    input logic           rx_sync,
    input logic           rx_bit,
    input logic           rx_valid,
    input logic           rx_data,
    input logic [CHW-1:0] rx_chan,
    input logic           tx_en,
    input logic           tx_sync,
    input logic           tx_ovh,
    input logic           tx_req,
    input logic           tx_chan_bit,
    input logic           tx_line
);
    // R10
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_valid);

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> $stable(tx_line));

    // R6
    t1_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_sync && !clear_mode && !link_e1) |=> !rx_valid);

    // R6
    ovh_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_sync && !clear_mode) |=> (tx_line == $past(tx_ovh)));

    // R7
    clear_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_sync && clear_mode) |=>
            (rx_valid && rx_chan == $past(clear_chan) && rx_data == $past(rx_bit)));

    // R9
    tx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> tx_en);

    // R9
    tx_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_req) |=> (tx_line == $past(tx_chan_bit)));
endmodule

bind tslot_mapper tsm_checker #(.CHW(CHW)) u_chk (
    .clk(clk), .rst_n(rst_n), .link_e1(link_e1), .clear_mode(clear_mode),
    .clear_chan(clear_chan), .rx_en(rx_en), .rx_sync(rx_sync), .rx_bit(rx_bit),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_chan(rx_chan),
    .tx_en(tx_en), .tx_sync(tx_sync), .tx_ovh(tx_ovh), .tx_req(tx_req),
    .tx_chan_bit(tx_chan_bit), .tx_line(tx_line)
);

// File: tb/test_tslot_mapper.sv
`timescale 1ns/1ps
module test_tslot_mapper;
    localparam int NCHAN = 8;
    localparam int CHW   = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           link_e1 = 1'b0, clear_mode = 1'b0;
    logic [CHW-1:0] clear_chan = '0;
    logic           tbl_we = 1'b0, tbl_en = 1'b0, tbl_f56 = 1'b0;
    logic [4:0]     tbl_addr = '0;
    logic [CHW-1:0] tbl_chan = '0;
    logic           rx_en = 1'b0, rx_sync = 1'b0, rx_bit = 1'b0;
    logic           rx_valid, rx_data, rx_first;
    logic [CHW-1:0] rx_chan;
    logic           tx_en = 1'b0, tx_sync = 1'b0, tx_ovh = 1'b0;
    logic           tx_req, tx_req_first, tx_line;
    logic [CHW-1:0] tx_req_chan;
    logic           tx_chan_bit;
    logic [15:0]    stim = 16'h1d3b;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int t_en[32], t_f56[32], t_ch[32];
    bit m_e1, m_clr, m_sync;
    int m_p, m_cch, mod_slot;
    bit mod_done;
    bit last_line;

    always #2.5 clk = ~clk;

    function automatic bit pat(int c, logic [15:0] s);
        return s[c % 16] ^ c[0];
    endfunction

    always_comb tx_chan_bit = pat(int'(tx_req_chan), stim);

    tslot_mapper #(.NCHAN(NCHAN)) i_tslot_mapper (
        .clk(clk), .rst_n(rst_n), .link_e1(link_e1), .clear_mode(clear_mode),
        .clear_chan(clear_chan), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_en(tbl_en), .tbl_f56(tbl_f56), .tbl_chan(tbl_chan),
        .rx_en(rx_en), .rx_sync(rx_sync), .rx_bit(rx_bit),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_chan(rx_chan), .rx_first(rx_first),
        .tx_en(tx_en), .tx_sync(tx_sync), .tx_ovh(tx_ovh), .tx_req(tx_req),
        .tx_req_chan(tx_req_chan), .tx_req_first(tx_req_first),
        .tx_chan_bit(tx_chan_bit), .tx_line(tx_line)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic tbl_write(int s, int en, int f56, int ch);
        @(negedge clk);
        rx_en = 0; tx_en = 0; rx_sync = 0; tx_sync = 0;
        tbl_we = 1; tbl_addr = 5'(s); tbl_en = en[0]; tbl_f56 = f56[0]; tbl_chan = CHW'(ch);
        @(posedge clk);
        #1;
        tbl_we = 0;
        t_en[s] = en; t_f56[s] = f56; t_ch[s] = ch;
    endtask

    // one line bit in both directions
    task automatic step(bit en, bit sy);
        bit fb, vpos, ovh_pos, carried, first, rxb, ovh, exp_line;
        int sl, bb, ch;
        string tg;
        @(negedge clk);
        stim = {stim[14:0], stim[15] ^ stim[13] ^ stim[12] ^ stim[10]};
        rxb = stim[7];
        ovh = stim[11];
        rx_en = en; tx_en = en; rx_sync = en && sy; tx_sync = en && sy;
        rx_bit = rxb; tx_ovh = ovh;
        if (en && sy) begin
            m_p = 0;
            m_sync = 1;
        end
        vpos = en && m_sync;
        fb = !m_e1 && m_p == 0;
        if (m_e1) begin
            sl = m_p / 8; bb = m_p % 8;
        end else begin
            sl = fb ? 0 : (m_p - 1) / 8;
            bb = fb ? 0 : (m_p - 1) % 8;
        end
        ovh_pos = vpos && !m_clr && (fb || (m_e1 && sl == 0));
        carried = vpos && (m_clr || (!ovh_pos && t_en[sl] != 0 && !(t_f56[sl] != 0 && bb == 7)));
        ch = m_clr ? m_cch : t_ch[sl];
        first = carried && !fb && bb == 0;
        if (!en) tg = "R10";
        else if (!m_sync) tg = "R2";
        else if (m_clr) tg = "R7";
        else if (ovh_pos) tg = "R6";
        else if (mod_done && sl == mod_slot) tg = "R11";
        else if (t_en[sl] == 0) tg = "R4";
        else if (t_f56[sl] != 0 && bb == 7) tg = "R5";
        else tg = "R3";
        if (!en) exp_line = last_line;
        else if (ovh_pos) exp_line = ovh;
        else if (carried) exp_line = pat(ch, stim);
        else exp_line = 1'b1;
        #1;
        check(tx_req == carried, tg, "tx_req", int'(tx_req), int'(carried));
        if (carried) begin
            check(int'(tx_req_chan) == ch, tg, "tx_req_chan", int'(tx_req_chan), ch);
            check(tx_req_first == first, "R8", "tx_req_first", int'(tx_req_first), int'(first));
        end
        @(posedge clk);
        #1;
        check(rx_valid == carried, tg, "rx_valid", int'(rx_valid), int'(carried));
        if (carried) begin
            check(rx_data == rxb, tg, "rx_data", int'(rx_data), int'(rxb));
            check(int'(rx_chan) == ch, tg, "rx_chan", int'(rx_chan), ch);
            check(rx_first == first, "R8", "rx_first", int'(rx_first), int'(first));
        end
        check(tx_line == exp_line, (tg == "R3") ? "R9" : tg, "tx_line", int'(tx_line), int'(exp_line));
        last_line = exp_line;
        if (vpos) m_p = (m_p + 1) % (m_e1 ? 256 : 193);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 6; k++) begin
            m_e1 = k[0];
            m_clr = (k >= 4);
            m_cch = (k * 3 + 2) % NCHAN;
            @(negedge clk);
            rst_n = 0; rx_en = 0; tx_en = 0; rx_sync = 0; tx_sync = 0; tbl_we = 0;
            link_e1 = m_e1; clear_mode = m_clr; clear_chan = CHW'(m_cch);
            repeat (3) @(posedge clk);
            #1;
            // R1: reset state
            check(rx_valid == 0, "R1", "rx_valid in reset", int'(rx_valid), 0);
            check(tx_line == 1, "R1", "tx_line in reset", int'(tx_line), 1);
            check(tx_req == 0, "R1", "tx_req in reset", int'(tx_req), 0);
            @(negedge clk);
            rst_n = 1;
            @(posedge clk);
            #1;
            check(tx_line == 1 && rx_valid == 0, "R1", "outputs after reset", int'(tx_line), 1);
            for (int s = 0; s < 32; s++) begin
                t_en[s] = 0; t_f56[s] = 0; t_ch[s] = 0;
            end
            m_sync = 0; m_p = 0; mod_done = 0; mod_slot = 3 + k;
            last_line = 1;
            for (int s = 0; s < 32; s++) begin
                if (k == 2 || k == 3)
                    tbl_write(s, 1, 0, NCHAN - 1);
                else
                    tbl_write(s, ((s * 5 + k) % 4) != 0, ((s + k) % 3) == 0, (s * 3 + k) % NCHAN);
            end
            // before the first frame marker nothing is carried (R2)
            for (int i = 0; i < 20; i++) step(1, 0);
            step(1, 1);
            for (int i = 0; i < 700; i++) begin
                if (i == 300) begin
                    tbl_write(mod_slot, t_en[mod_slot] == 0, t_f56[mod_slot] == 0,
                              (t_ch[mod_slot] + 1) % NCHAN);
                    mod_done = 1;
                end
                step(stim[3:2] != 2'b00, i == 450);
            end
        end
        finish_run();
    end
endmodule